// File: doc/BRIEF.md
# Transceiver Error Pin Status Multiplexer

This block drives a single active-low status pin for a bus transceiver. It keeps the set/clear state of four internal flags: wake-up source, bus failure, local failure and power-on. At any moment it puts exactly one of them on the pin, or no flag at all. Which flag is shown depends on the operating mode and, in Normal mode, on how many qualified dominant-to-recessive edges the transmit data line has made since Normal mode was last entered. Mode decoding and analog fault detection sit outside the block. They arrive as a 2-bit mode code and one-cycle set requests.

In Normal mode the pin first reports the wake-up source. After four qualified transmit edges it switches to reporting bus failures. In the power-on/listen-only mode it reports local failures when that mode was entered from Normal. When the mode was entered any other way it can report the power-on flag instead. Each flag has its own clear rule tied to mode transitions. After every mode change the pin is frozen for a settling window so that software never samples a half-switched value.

Top module: `errpin_status_mux`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `err_n_o` is high and every flag is clear.
- R2: With the mode steady and the settling window over, `err_n_o` is low exactly when the selected flag is set, and high when it is clear or when no flag is selected. The flags are selected on the registered mode and state, one clock after a flag changes.
- R3: Mode codes are 2'b00 sleep, 2'b01 standby, 2'b10 Normal and 2'b11 listen-only. In Normal mode, while fewer than EDGE_TARGET (4) qualified transmit edges have been counted, the pin shows the wake-up-source flag.
- R4: In Normal mode, once EDGE_TARGET qualified edges have been counted, the pin shows the bus-failure flag. The count saturates at EDGE_TARGET and resets to zero on every entry into Normal mode.
- R5: A transmit rising edge (txd_i 0 to 1, with 0 meaning dominant) is counted only in Normal mode and only if txd_i was low for at least MIN_DOM_CYC consecutive cycles just before the edge. Shorter pulses do not advance the count.
- R6: In listen-only mode entered from Normal, the pin shows the local-failure flag. In listen-only mode entered from any other mode it shows the power-on flag (LISTEN_PWON_EN=1). In sleep and standby no flag is shown and the pin goes high.
- R7: The wake-up-source flag is set by `set_wake_src_i`. It clears when Normal mode is left or when `set_pwon_i` is asserted, and a clear wins over a set in the same cycle.
- R8: The bus-failure flag is set by `set_bus_fail_i` and clears on entry into Normal mode.
- R9: The local-failure flag is set by `set_local_fail_i`. It clears on entry into Normal mode, or in a cycle where rxd_i is 0, txd_i is 1 and `local_ok_i` is 1. The rxd/txd condition has no effect while `local_ok_i` is 0.
- R10: The power-on flag is set by `set_pwon_i` and clears on entry into Normal mode.
- R11: A mode change at a clock edge freezes `err_n_o` at that edge and for the next SETTLE_CYC edges. The pin takes up the new selection at the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode code (see R3) |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| rxd_i | input | 1 | Receive data, 0 = dominant |
| set_wake_src_i | input | 1 | Set request, wake-up-source flag |
| set_bus_fail_i | input | 1 | Set request, bus-failure flag |
| set_local_fail_i | input | 1 | Set request, local-failure flag |
| set_pwon_i | input | 1 | Set request, power-on flag |
| local_ok_i | input | 1 | All local failures resolved |
| err_n_o | output | 1 | Active-low status pin |

## Verification
The assertions check the rules that hold on every cycle:
- the reset value of the pin;
- the freeze of the pin on the edge that follows a mode change;
- the clearing of the bus-failure flag on Normal entry;
- the clearing of the wake-up flag by a power-on request;
- the qualified local-failure clear;
- the bound on the transmit edge count.

The handover from wake-up source to bus failure after the fourth long dominant pulse, the rejection of short pulses and the length of the settling window depend on long input histories. Only the bench's scenarios show them. They are compared each clock against a behavioural model. The choice between local-failure and power-on display in listen-only mode, which depends on the previous mode, is likewise shown only by the scenarios.

// File: rtl/errpin_pkg.sv
package errpin_pkg;

   typedef enum logic [1:0] {
      MODE_SLEEP   = 2'b00,
      MODE_STANDBY = 2'b01,
      MODE_NORMAL  = 2'b10,
      MODE_LISTEN  = 2'b11
   } op_mode_e;

   typedef struct packed {
      logic wake_src;
      logic bus_fail;
      logic local_fail;
      logic pwon;
   } flag_set_t;

endpackage

// File: rtl/errpin_edge_counter.sv
module errpin_edge_counter #(
   parameter int unsigned MIN_DOM_CYC = 400,
   parameter int unsigned EDGE_TARGET = 4,
   localparam int unsigned DW = $clog2(MIN_DOM_CYC + 1),
   localparam int unsigned EW = $clog2(EDGE_TARGET + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          txd_i,
   input  logic          count_en_i,
   input  logic          restart_i,
   output logic [EW-1:0] edges_o,
   output logic          target_hit_o
);
   localparam logic [DW-1:0] DOM_MAX  = DW'(MIN_DOM_CYC);
   localparam logic [EW-1:0] EDGE_MAX = EW'(EDGE_TARGET);

   if (MIN_DOM_CYC < 1) begin : g_bad_dom
      $error("MIN_DOM_CYC must be at least 1");
   end
   if (EDGE_TARGET < 1) begin : g_bad_target
      $error("EDGE_TARGET must be at least 1");
   end

   logic [DW-1:0] dom_q;
   logic          long_rise;

   // dominant run length, saturating once the minimum is met
   always_ff @(posedge clk) begin
      if (!rst_n)                dom_q <= '0;
      else if (txd_i)            dom_q <= '0;
      else if (dom_q != DOM_MAX) dom_q <= dom_q + 1'b1;
   end

   assign long_rise = txd_i && (dom_q == DOM_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n || restart_i)
         edges_o <= '0;
      else if (count_en_i && long_rise && (edges_o != EDGE_MAX))
         edges_o <= edges_o + 1'b1;
   end

   assign target_hit_o = (edges_o == EDGE_MAX);

endmodule

// File: rtl/errpin_flag_bank.sv
module errpin_flag_bank
   import errpin_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enter_normal_i,
   input  logic      leave_normal_i,
   input  logic      set_wake_src_i,
   input  logic      set_bus_fail_i,
   input  logic      set_local_fail_i,
   input  logic      set_pwon_i,
   input  logic      txd_i,
   input  logic      rxd_i,
   input  logic      local_ok_i,
   output flag_set_t flags_o
);
   flag_set_t clr, set;

   always_comb begin
      set.wake_src   = set_wake_src_i;
      set.bus_fail   = set_bus_fail_i;
      set.local_fail = set_local_fail_i;
      set.pwon       = set_pwon_i;

      clr.wake_src   = leave_normal_i || set_pwon_i;
      clr.bus_fail   = enter_normal_i;
      clr.local_fail = enter_normal_i || (!rxd_i && txd_i && local_ok_i);
      clr.pwon       = enter_normal_i;
   end

   // clear takes priority over set for every flag
   always_ff @(posedge clk) begin
      if (!rst_n) flags_o <= '0;
      else        flags_o <= (flags_o | set) & ~clr;
   end

endmodule

// File: rtl/errpin_out_stage.sv
module errpin_out_stage
   import errpin_pkg::*;
#(
   parameter int unsigned SETTLE_CYC     = 800,
   parameter bit          LISTEN_PWON_EN = 1'b1,
   localparam int unsigned HW = $clog2(SETTLE_CYC + 1)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mode_change_i,
   input  op_mode_e  mode_q_i,
   input  logic      from_normal_i,
   input  logic      target_hit_i,
   input  flag_set_t flags_i,
   output logic      err_n_o
);
   localparam logic [HW-1:0] HOLD_LOAD = HW'(SETTLE_CYC);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   logic          listen_alt;
   logic          shown;
   logic [HW-1:0] hold_q;

   if (LISTEN_PWON_EN) begin : g_listen_pwon
      assign listen_alt = flags_i.pwon;
   end else begin : g_listen_none
      assign listen_alt = 1'b0;
   end

   always_comb begin
      unique case (mode_q_i)
         MODE_NORMAL: shown = target_hit_i  ? flags_i.bus_fail   : flags_i.wake_src;
         MODE_LISTEN: shown = from_normal_i ? flags_i.local_fail : listen_alt;
         default:     shown = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         err_n_o <= 1'b1;
      end else if (mode_change_i) begin
         hold_q  <= HOLD_LOAD;
      end else if (hold_q != '0) begin
         hold_q  <= hold_q - 1'b1;
      end else begin
         err_n_o <= ~shown;
      end
   end

endmodule

// File: rtl/errpin_status_mux.sv
module errpin_status_mux
   import errpin_pkg::*;
#(
   parameter int unsigned MIN_DOM_CYC    = 400,
   parameter int unsigned SETTLE_CYC     = 800,
   parameter int unsigned EDGE_TARGET    = 4,
   parameter bit          LISTEN_PWON_EN = 1'b1,
   localparam int unsigned EW = $clog2(EDGE_TARGET + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       txd_i,
   input  logic       rxd_i,
   input  logic       set_wake_src_i,
   input  logic       set_bus_fail_i,
   input  logic       set_local_fail_i,
   input  logic       set_pwon_i,
   input  logic       local_ok_i,
   output logic       err_n_o
);
   op_mode_e      mode_now, mode_q;
   logic          from_normal_q;
   logic          mode_change, enter_normal, leave_normal;
   logic [EW-1:0] edge_cnt;
   logic          target_hit;
   flag_set_t     flags_q;

   assign mode_now     = op_mode_e'(mode_i);
   assign mode_change  = (mode_now != mode_q);
   assign enter_normal = (mode_now == MODE_NORMAL) && (mode_q != MODE_NORMAL);
   assign leave_normal = (mode_now != MODE_NORMAL) && (mode_q == MODE_NORMAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q        <= MODE_SLEEP;
         from_normal_q <= 1'b0;
      end else begin
         mode_q <= mode_now;
         if (mode_change && (mode_now == MODE_LISTEN))
            from_normal_q <= (mode_q == MODE_NORMAL);
      end
   end

   errpin_edge_counter #(
      .MIN_DOM_CYC (MIN_DOM_CYC),
      .EDGE_TARGET (EDGE_TARGET)
   ) i_edges (
      .clk          (clk),
      .rst_n        (rst_n),
      .txd_i        (txd_i),
      .count_en_i   (mode_now == MODE_NORMAL),
      .restart_i    (enter_normal),
      .edges_o      (edge_cnt),
      .target_hit_o (target_hit)
   );

   errpin_flag_bank i_flags (
      .clk              (clk),
      .rst_n            (rst_n),
      .enter_normal_i   (enter_normal),
      .leave_normal_i   (leave_normal),
      .set_wake_src_i   (set_wake_src_i),
      .set_bus_fail_i   (set_bus_fail_i),
      .set_local_fail_i (set_local_fail_i),
      .set_pwon_i       (set_pwon_i),
      .txd_i            (txd_i),
      .rxd_i            (rxd_i),
      .local_ok_i       (local_ok_i),
      .flags_o          (flags_q)
   );

   errpin_out_stage #(
      .SETTLE_CYC     (SETTLE_CYC),
      .LISTEN_PWON_EN (LISTEN_PWON_EN)
   ) i_out (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_change_i (mode_change),
      .mode_q_i      (mode_q),
      .from_normal_i (from_normal_q),
      .target_hit_i  (target_hit),
      .flags_i       (flags_q),
      .err_n_o       (err_n_o)
   );

endmodule

// File: rtl/errpin_status_chk.sv
module errpin_status_chk #(
   parameter int unsigned EW     = 3,
   parameter int unsigned TARGET = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mode_i,
   input logic          txd_i,
   input logic          rxd_i,
   input logic          local_ok_i,
   input logic          set_pwon_i,
   input logic          err_n_o,
   input logic          wake_q,
   input logic          bus_q,
   input logic          local_q,
   input logic [EW-1:0] edge_cnt
);
   // R1
   reset_high_chk: assert property (@(posedge clk)
      !rst_n |=> err_n_o);

   // R11
   settle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != $past(mode_i)) |=> $stable(err_n_o));

   // R8
   bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == 2'b10) && ($past(mode_i) != 2'b10)) |=> !bus_q);

   // R7
   wake_pwon_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_pwon_i |=> !wake_q);

   // R9
   local_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rxd_i && txd_i && local_ok_i) |=> !local_q);

   // R4
   edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_cnt <= EW'(TARGET));

endmodule

bind errpin_status_mux errpin_status_chk #(
   .EW     (EW),
   .TARGET (EDGE_TARGET)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .txd_i      (txd_i),
   .rxd_i      (rxd_i),
   .local_ok_i (local_ok_i),
   .set_pwon_i (set_pwon_i),
   .err_n_o    (err_n_o),
   .wake_q     (flags_q.wake_src),
   .bus_q      (flags_q.bus_fail),
   .local_q    (flags_q.local_fail),
   .edge_cnt   (edge_cnt)
);

// File: tb/test_errpin_status_mux.sv
module test_errpin_status_mux;
   localparam int MIN_DOM = 6;
   localparam int SETTLE  = 12;
   localparam int TARGET  = 4;
   localparam logic [1:0] SLP = 2'b00, STB = 2'b01, NRM = 2'b10, LST = 2'b11;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] mode_i = SLP;
   logic txd_i = 1'b1, rxd_i = 1'b1;
   logic set_wake = 1'b0, set_bus = 1'b0, set_local = 1'b0, set_pwon = 1'b0, local_ok = 1'b0;
   logic err_n_o;

   always #5 clk = ~clk;

   errpin_status_mux #(
      .MIN_DOM_CYC (MIN_DOM), .SETTLE_CYC (SETTLE),
      .EDGE_TARGET (TARGET), .LISTEN_PWON_EN (1'b1)
   ) i_errpin_status_mux (
      .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .txd_i (txd_i), .rxd_i (rxd_i),
      .set_wake_src_i (set_wake), .set_bus_fail_i (set_bus), .set_local_fail_i (set_local),
      .set_pwon_i (set_pwon), .local_ok_i (local_ok), .err_n_o (err_n_o)
   );

   int total = 0, bad = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural reference
   int  m_mode, m_hold, m_edges, m_dom;
   bit  m_wake, m_bus, m_local, m_pwon, m_fromn, m_err, m_sel;
   bit  chg, ent, lv;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = SLP; m_hold = 0; m_edges = 0; m_dom = 0;
         m_wake = 0; m_bus = 0; m_local = 0; m_pwon = 0; m_fromn = 0; m_err = 1;
      end else begin
         chg = (int'(mode_i) != m_mode);
         ent = (mode_i == NRM) && (m_mode != NRM);
         lv  = (mode_i != NRM) && (m_mode == NRM);
         if (m_mode == NRM)      m_sel = (m_edges >= TARGET) ? m_bus : m_wake;
         else if (m_mode == LST) m_sel = m_fromn ? m_local : m_pwon;
         else                    m_sel = 0;
         if (chg)             m_hold = SETTLE;
         else if (m_hold > 0) m_hold--;
         else                 m_err = !m_sel;
         if (lv || set_pwon) m_wake = 0; else if (set_wake) m_wake = 1;
         if (ent) m_bus = 0; else if (set_bus) m_bus = 1;
         if (ent || (!rxd_i && txd_i && local_ok)) m_local = 0; else if (set_local) m_local = 1;
         if (ent) m_pwon = 0; else if (set_pwon) m_pwon = 1;
         if (ent) m_edges = 0;
         else if (mode_i == NRM && txd_i && m_dom >= MIN_DOM && m_edges < TARGET) m_edges++;
         if (txd_i) m_dom = 0; else if (m_dom < MIN_DOM) m_dom++;
         if (chg && mode_i == LST) m_fromn = (m_mode == NRM);
         m_mode = int'(mode_i);
      end
   end

   // R2: model comparison every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (err_n_o !== m_err) begin
            bad++;
            $display("FAIL R2/%s model: actual=%b expected=%b at %0t", tag, err_n_o, m_err, $time);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_pin(input logic exp, input string req);
      total++;
      if (err_n_o !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, err_n_o, exp, $time);
      end
   endtask

   task automatic pulse(input int len);
      txd_i = 1'b0; step(len);
      txd_i = 1'b1; step(3);
   endtask

   task automatic request(ref logic sig);
      sig = 1'b1; step(1); sig = 1'b0;
   endtask

   task automatic go(input logic [1:0] m);
      mode_i = m; step(SETTLE + 4);
   endtask

   initial begin
      step(5);
      expect_pin(1'b1, "R1 in reset");
      rst_n = 1'b1; step(1);
      expect_pin(1'b1, "R1 after reset");

      tag = "R3"; go(STB);
      request(set_wake); step(2);
      go(NRM);
      expect_pin(1'b0, "R3 wake shown in Normal");

      tag = "R5";
      for (int i = 0; i < 5; i++) pulse(MIN_DOM - 2);
      expect_pin(1'b0, "R5 short pulses ignored");
      for (int i = 0; i < TARGET - 1; i++) pulse(MIN_DOM + 2);
      expect_pin(1'b0, "R3 three edges still wake");
      tag = "R4"; pulse(MIN_DOM);
      expect_pin(1'b1, "R4 bus flag clear after fourth edge");
      request(set_bus); step(2);
      expect_pin(1'b0, "R4 bus flag set");
      pulse(MIN_DOM + 1);
      expect_pin(1'b0, "R4 saturated count keeps bus");

      tag = "R6"; request(set_local); step(1);
      go(LST);
      expect_pin(1'b0, "R6 local shown after Normal");
      tag = "R9";
      rxd_i = 1'b0; txd_i = 1'b1; local_ok = 1'b0; step(3);
      expect_pin(1'b0, "R9 unresolved keeps local");
      local_ok = 1'b1; step(3);
      rxd_i = 1'b1; local_ok = 1'b0;
      expect_pin(1'b1, "R9 resolved clears local");
      request(set_local); step(2);
      expect_pin(1'b0, "R9 local set again");

      tag = "R11"; mode_i = STB; step(6);
      expect_pin(1'b0, "R11 held in window");
      step(SETTLE);
      expect_pin(1'b1, "R11 standby shows none");

      tag = "R7"; request(set_local);
      set_wake = 1'b1; set_pwon = 1'b1; step(1);
      set_wake = 1'b0; set_pwon = 1'b0; step(1);
      tag = "R10"; go(LST);
      expect_pin(1'b0, "R10 pwon shown in listen from standby");
      tag = "R7"; go(NRM);
      expect_pin(1'b1, "R7 wake cleared by pwon");
      tag = "R8";
      for (int i = 0; i < TARGET; i++) pulse(MIN_DOM + 1);
      expect_pin(1'b1, "R8 bus cleared on entry");
      tag = "R9"; go(LST);
      expect_pin(1'b1, "R9 local cleared on Normal entry");
      tag = "R10"; go(STB); go(LST);
      expect_pin(1'b1, "R10 pwon cleared on Normal entry");
      tag = "R7"; go(NRM); request(set_wake); step(2);
      expect_pin(1'b0, "R7 wake set in Normal");
      go(SLP); go(NRM);
      expect_pin(1'b1, "R7 wake cleared on leaving Normal");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule